// File: doc/BRIEF.md
# Guarded Rule Scheduler and State Combiner

This block decides, every clock cycle, which of a fixed set of guarded state-update rules are allowed to take effect, and then applies their proposed values to a small bank of state registers. Each rule presents a ready bit and one candidate value for every register. A compile-time table lists which rule pairs clash. A second table lists the ordered pairs that may share a register when applied one after the other. A third table says which registers each rule writes.

The scheduler has two variants, chosen by a parameter. `SCHED_ONE` grants a single rule per cycle, and the lowest-index ready rule wins. `SCHED_MANY` walks the rules from index 0 upward. A ready rule is granted unless a rule already granted earlier in the walk clashes with it. This gives lowest-index priority inside each clashing group while separate groups proceed on their own. The grants drive a per-register combiner that forms the write enable and picks the next value. The registers update on the rising edge and hold when nobody writes them.

The scheduler and the combiners are purely combinational. The only state is the register bank. A synchronous active-high reset loads it from a parameter.

Top module: `rule_sched_core`

## Requirements
- R1: A `will_fire` bit is only ever high when the matching `can_fire` bit is high.
- R2: Whenever at least one `can_fire` bit is high, at least one `will_fire` bit is high in the same cycle.
- R3: With MODE = SCHED_ONE, `will_fire` is either zero or one-hot, and the granted rule is the lowest-index ready rule.
- R4: With MODE = SCHED_MANY, two rules marked as clashing are never granted in the same cycle. The default clash pairs are {0,1} and {2,3}, with CONFLICT bit i*N+j set for each ordered pair.
- R5: With MODE = SCHED_MANY, rule i is granted exactly when it is ready and no lower-index granted rule clashes with it. With the defaults, all four rules ready gives `will_fire` = 4'b0101.
- R6: `reg_we[g]` is high exactly when some granted rule writes register g. WRITES bit r*NREG+g marks rule r as a writer of g. By default rule 0 writes reg 0, rule 1 writes regs 0 and 1, rule 2 writes regs 1 and 2, and rule 3 writes reg 2.
- R7: On a rising edge with `reg_we[g]` high, register g takes the candidate value of its granted writer. The value comes from slice `rule_val[(r*NREG+g)*DW +: DW]`. With `reg_we[g]` low, the register keeps its value.
- R8: When two granted rules write the same register, the pair must be marked sequentially composable (SEQ bit a*N+b, a<b). The higher-index rule's value is stored. By default only pair (1,2) is marked this way, and it shares reg 1.
- R9: A rising edge with `rst` high loads every register from INIT (default reg0=0x01, reg1=0x02, reg2=0x03). `reg_q` packs register g at bits g*DW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| can_fire | input | N | Ready predicate of each rule |
| rule_val | input | N*NREG*DW | Candidate value of each rule for each register |
| will_fire | output | N | Grant of each rule this cycle |
| reg_we | output | NREG | Write enable of each register |
| reg_q | output | NREG*DW | Current register contents |

## Verification
Two functions can meet in one cycle: the multi-grant scheduler and the shared-register combiner. This happens when the scheduler grants a sequentially composable pair that both write the same register, which puts two writers on one combiner. The bench provokes it on purpose with rules 1 and 2 ready and rule 0 idle, and also with random ready patterns. It then checks that both rules are granted, that reg 1 stores rule 2's value, and that reg 0 stores rule 1's value. A second instance in single-grant mode sees the same stimulus and must pick only one rule.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic {
        SCHED_ONE  = 1'b0,
        SCHED_MANY = 1'b1
    } sched_mode_e;

endpackage

// File: rtl/rsc_pick.sv
module rsc_pick
    import rsc_pkg::*;
#(
    parameter int          N        = 4,
    parameter sched_mode_e MODE     = SCHED_MANY,
    parameter logic [N*N-1:0] CONFLICT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] can_fire,
    output logic [N-1:0] will_fire
);

    // Walk from rule 0 upward; a rule is blocked by an earlier grant
    always_comb begin
        logic [N-1:0] got;
        logic         blk;
        got = '0;
        for (int i = 0; i < N; i++) begin
            if (MODE == SCHED_MANY)
                blk = |(got & CONFLICT[i*N +: N]);
            else
                blk = |got;
            got[i] = can_fire[i] & ~blk;
        end
        will_fire = got;
    end

    generate
        if (MODE == SCHED_ONE) begin : g_one
            a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
                $onehot0(will_fire));
        end else begin : g_many
            for (genvar i = 0; i < N; i++) begin : g_i
                for (genvar j = i + 1; j < N; j++) begin : g_j
                    if (CONFLICT[i*N+j]) begin : g_clash
                        a_r4_no_clash_pair: assert property (@(posedge clk) disable iff (rst)
                            !(will_fire[i] && will_fire[j]));
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rsc_merge.sv
module rsc_merge #(
    parameter int N    = 4,
    parameter int NREG = 3,
    parameter int DW   = 8,
    parameter int IDX  = 0,
    parameter logic [N*NREG-1:0] WRITES = '0,
    parameter logic [N*N-1:0]    SEQ    = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         will_fire,
    input  logic [N*NREG*DW-1:0] rule_val,
    input  logic [DW-1:0]        cur,
    output logic                 we,
    output logic [DW-1:0]        nxt
);

    // Later writers override earlier ones, so the higher index wins
    always_comb begin
        we  = 1'b0;
        nxt = cur;
        for (int r = 0; r < N; r++) begin
            if (WRITES[r*NREG+IDX] && will_fire[r]) begin
                we  = 1'b1;
                nxt = rule_val[(r*NREG+IDX)*DW +: DW];
            end
        end
    end

    generate
        for (genvar a = 0; a < N; a++) begin : g_a
            for (genvar b = a + 1; b < N; b++) begin : g_b
                if (WRITES[a*NREG+IDX] && WRITES[b*NREG+IDX] && !SEQ[a*N+b]) begin : g_chk
                    a_r8_single_writer: assert property (@(posedge clk) disable iff (rst)
                        !(will_fire[a] && will_fire[b]));
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rsc_state.sv
module rsc_state #(
    parameter int NREG = 3,
    parameter int DW   = 8,
    parameter logic [NREG*DW-1:0] INIT = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NREG-1:0]    we,
    input  logic [NREG*DW-1:0] nxt,
    output logic [NREG*DW-1:0] q
);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    q[g*DW +: DW] <= INIT[g*DW +: DW];
                else if (we[g])
                    q[g*DW +: DW] <= nxt[g*DW +: DW];
            end

            a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
                !we[g] |=> $stable(q[g*DW +: DW]));
        end
    endgenerate

    a_r9_reset_load: assert property (@(posedge clk)
        rst |=> (q == INIT));

endmodule

// File: rtl/rule_sched_core.sv
module rule_sched_core
    import rsc_pkg::*;
#(
    parameter int          N    = 4,
    parameter int          NREG = 3,
    parameter int          DW   = 8,
    parameter sched_mode_e MODE = SCHED_MANY,
    parameter logic [N*N-1:0]     CONFLICT = 16'h4812,
    parameter logic [N*N-1:0]     SEQ      = 16'h0040,
    parameter logic [N*NREG-1:0]  WRITES   = 12'h999,
    parameter logic [NREG*DW-1:0] INIT     = 24'h030201
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         can_fire,
    input  logic [N*NREG*DW-1:0] rule_val,
    output logic [N-1:0]         will_fire,
    output logic [NREG-1:0]      reg_we,
    output logic [NREG*DW-1:0]   reg_q
);

    logic [NREG*DW-1:0] nxt_all;

    rsc_pick #(
        .N(N), .MODE(MODE), .CONFLICT(CONFLICT)
    ) u_pick (
        .clk(clk), .rst(rst), .can_fire(can_fire), .will_fire(will_fire)
    );

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_merge
            rsc_merge #(
                .N(N), .NREG(NREG), .DW(DW), .IDX(g), .WRITES(WRITES), .SEQ(SEQ)
            ) u_merge (
                .clk(clk), .rst(rst), .will_fire(will_fire), .rule_val(rule_val),
                .cur(reg_q[g*DW +: DW]), .we(reg_we[g]), .nxt(nxt_all[g*DW +: DW])
            );
        end
    endgenerate

    rsc_state #(
        .NREG(NREG), .DW(DW), .INIT(INIT)
    ) u_state (
        .clk(clk), .rst(rst), .we(reg_we), .nxt(nxt_all), .q(reg_q)
    );

    a_r1_grant_needs_ready: assert property (@(posedge clk) disable iff (rst)
        (will_fire & ~can_fire) == '0);

    a_r2_no_idle: assert property (@(posedge clk) disable iff (rst)
        (|can_fire) |-> (|will_fire));

endmodule

// File: tb/tb_rule_sched_core.sv
module tb_rule_sched_core;
    import rsc_pkg::*;

    localparam logic [15:0] B_CONF = 16'h4812;
    localparam logic [11:0] B_WR   = 12'h999;
    localparam logic [23:0] B_INIT = 24'h030201;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cf  = '0;
    logic [95:0] val = '0;
    logic [3:0]  wf_m, wf_s;
    logic [2:0]  we_m, we_s;
    logic [23:0] q_m, q_s;
    logic [23:0] eq_m, eq_s;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    rule_sched_core dut (
        .clk(clk), .rst(rst), .can_fire(cf), .rule_val(val),
        .will_fire(wf_m), .reg_we(we_m), .reg_q(q_m)
    );

    rule_sched_core #(.MODE(SCHED_ONE)) dut_one (
        .clk(clk), .rst(rst), .can_fire(cf), .rule_val(val),
        .will_fire(wf_s), .reg_we(we_s), .reg_q(q_s)
    );

    function automatic logic [3:0] m_wf(input logic [3:0] c, input bit many);
        logic [3:0] got = '0;
        for (int i = 0; i < 4; i++) begin
            logic blk;
            blk = many ? |(got & B_CONF[i*4 +: 4]) : |got;
            got[i] = c[i] & ~blk;
        end
        return got;
    endfunction

    function automatic logic [2:0] m_we(input logic [3:0] w);
        logic [2:0] e = '0;
        for (int g = 0; g < 3; g++)
            for (int r = 0; r < 4; r++)
                if (w[r] && B_WR[r*3+g]) e[g] = 1'b1;
        return e;
    endfunction

    function automatic logic [23:0] m_next(input logic [3:0] w, input logic [95:0] v,
                                           input logic [23:0] q);
        logic [23:0] n = q;
        for (int g = 0; g < 3; g++)
            for (int r = 0; r < 4; r++)
                if (w[r] && B_WR[r*3+g]) n[g*8 +: 8] = v[(r*3+g)*8 +: 8];
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] c, input logic [95:0] v);
        logic [3:0] ewm, ews;
        @(negedge clk);
        cf  = c;
        val = v;
        #1;
        ewm = m_wf(c, 1'b1);
        ews = m_wf(c, 1'b0);
        check(wf_m == ewm, "R1 R2 R4 R5 multi grant", {28'd0, wf_m}, {28'd0, ewm});
        check(wf_s == ews, "R1 R2 R3 single grant", {28'd0, wf_s}, {28'd0, ews});
        check(we_m == m_we(ewm), "R6 multi enable", {29'd0, we_m}, {29'd0, m_we(ewm)});
        check(we_s == m_we(ews), "R6 single enable", {29'd0, we_s}, {29'd0, m_we(ews)});
        eq_m = m_next(ewm, v, eq_m);
        eq_s = m_next(ews, v, eq_s);
        @(posedge clk);
        #1;
        check(q_m == eq_m, "R7 R8 multi regs", {8'd0, q_m}, {8'd0, eq_m});
        check(q_s == eq_s, "R7 single regs", {8'd0, q_s}, {8'd0, eq_s});
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [95:0] v;
        void'($urandom(32'd2718));
        repeat (2) @(posedge clk);
        #1;
        check(q_m == B_INIT, "R9 reset load", {8'd0, q_m}, {8'd0, B_INIT});
        check(q_s == B_INIT, "R9 reset load single", {8'd0, q_s}, {8'd0, B_INIT});
        eq_m = B_INIT;
        eq_s = B_INIT;
        @(negedge clk);
        rst = 1'b0;

        // R5: all ready -> groups {0,1},{2,3} each grant lowest
        step(4'b1111, {12{8'hA5}} ^ 96'h0123456789ABCDEF0011);
        check(wf_m == 4'b0101, "R5 all ready pattern", {28'd0, wf_m}, 32'h5);
        // R8: composable pair 1,2 shares reg1, rule 2 wins
        v = '0;
        v[(1*3+1)*8 +: 8] = 8'h11;
        v[(2*3+1)*8 +: 8] = 8'h22;
        v[(1*3+0)*8 +: 8] = 8'h33;
        v[(2*3+2)*8 +: 8] = 8'h44;
        step(4'b0110, v);
        check(q_m[15:8] == 8'h22, "R8 later rule wins", {24'd0, q_m[15:8]}, 32'h22);
        check(q_s[15:8] == 8'h11, "R3 single grant only rule1", {24'd0, q_s[15:8]}, 32'h11);
        // R7: nothing ready -> hold
        step(4'b0000, ~v);
        check(we_m == 3'b000, "R7 idle no write", {29'd0, we_m}, 32'h0);
        // R4: only clashing pair 2,3
        step(4'b1100, {$urandom, $urandom, $urandom});

        for (int k = 0; k < 400; k++)
            step(4'($urandom), {$urandom, $urandom, $urandom});

        // R9: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(q_m == B_INIT, "R9 reset mid run", {8'd0, q_m}, {8'd0, B_INIT});

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule